// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block drives the six gate signals of a three-phase inverter bridge. A single 16-bit counter ramps up from zero to a programmed peak and back down. Each of the three phases compares this shared count against its own signed duty value to produce a centered pulse. A complementary pair of outputs is then derived from that pulse, with a programmable guard interval before either side turns on.

Duty values are written into shadow registers at any time. They reach the comparators only at fixed points in the period: at the valley, and optionally also at the peak. This keeps a write in mid-period from producing a glitch. An external sync input restarts the period. Per-pin enables and a per-phase pair swap support brushless-DC commutation. A global polarity bit sets the active level of the pins. A shutdown input forces every pin to its inactive level without waiting for a clock, and a sticky trip flag keeps the pins off until it is cleared.

Top module: `pwm3_center_top`

## Requirements
- R1: While reset is asserted, with dead time 0 and polarity 1, pwm_o reads 6'b101010 (low-side pins on, high-side pins off) and trip_o is 0.
- R2: With active peak value P, the counter runs 0,1,..,P,P-1,..,1 and repeats, so one period lasts 2P clocks. The peak value is taken from period_i only when the counter returns to 0.
- R3: For phase k, the duty is duty_i[16k+15:16k] in two's complement, and L = floor(P/2) + duty. When 0 < L < P, the high-side pin pwm_o[2k] is on for 2L-1 clocks of each period and the low-side pin pwm_o[2k+1] is on for the rest, provided dead time is 0.
- R4: If L <= 0, the high side stays off for the whole period. If L >= P, the high side stays on for the whole period. In both clamped cases no dead time is removed from either pin.
- R5: With dead time D, each pin turns on D clocks after its phase changes level, so each pin loses D clocks per period. The two pins of a pair are never on together.
- R6: sync_i sampled high at a clock edge restarts the counter at 0 and loads all shadow values. The first restarted period then appears on pwm_o for the 2P clocks that follow the next edge.
- R7: With dbl_i at 0, a duty written during a period takes effect only from the next valley.
- R8: With dbl_i at 1, a duty written during the up ramp also takes effect at the peak. That period then shows L_old + L_new - 1 high clocks.
- R9: Clearing en_i[j] holds pin pwm_o[j] at its inactive level; the other pins are unaffected.
- R10: Setting xov_i[k] exchanges the drive of pins 2k and 2k+1.
- R11: With pol_i at 0, every pin is inverted, so the inactive level is 1.
- R12: While shdn_i is high, every pin sits at its inactive level in the same cycle, with no clock edge needed.
- R13: shdn_i sampled high sets trip_o, which keeps all pins inactive after shdn_i falls. A clr_i pulse clears trip_o only if shdn_i is low at that edge, and output resumes after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | 16 | Peak count P |
| duty_i | input | 48 | Three signed duty values, phase k in bits 16k+15:16k |
| duty_wr_i | input | 1 | Load duty_i into the shadow registers |
| dbl_i | input | 1 | 1: load at peak and valley; 0: valley only |
| dt_i | input | 8 | Dead time in clocks |
| sync_i | input | 1 | Restart the period |
| en_i | input | 6 | Per-pin enable |
| xov_i | input | 3 | Per-phase pair swap |
| pol_i | input | 1 | 1: active-high pins; 0: active-low pins |
| shdn_i | input | 1 | Asynchronous shutdown |
| clr_i | input | 1 | Clear the trip flag |
| pwm_o | output | 6 | Gate pins, 2k high side and 2k+1 low side of phase k |
| trip_o | output | 1 | Latched shutdown flag |

## Verification
A sync pulse sampled at edge E0 sets the counter to 0 at that edge. The comparator result is registered one edge later, so the samples taken after edges E0+1 through E0+2P cover exactly one period. The scoreboard therefore pushes each expected per-pin on-count with a start cycle of E0+1, and the monitor integrates over that window. Dead-time windows start one whole period later, so that the transient left by the restart does not enter the count. Shutdown gating is checked a fraction of a cycle after shdn_i moves, before any edge. The trip flag is checked on the sample after the edge that sets it or clears it.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} dir_e;
endpackage

// File: rtl/pwm3_timebase.sv
module pwm3_timebase
  import pwm3_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period_i,
  input  logic          sync_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] per_o,
  output logic          vload_o,
  output logic          pload_o
);
  logic [CW-1:0] cnt_q, cnt_d, per_q, per_d;
  dir_e          dir_q, dir_d;

  always_comb begin
    cnt_d   = cnt_q;
    dir_d   = dir_q;
    vload_o = 1'b0;
    pload_o = 1'b0;
    if (sync_i) begin
      cnt_d   = '0;
      dir_d   = DIR_UP;
      vload_o = 1'b1;
    end else if (dir_q == DIR_UP) begin
      if (cnt_q >= per_q) begin
        if (per_q <= CW'(1)) begin
          cnt_d   = '0;
          vload_o = 1'b1;
        end else begin
          cnt_d = per_q - CW'(1);
          dir_d = DIR_DN;
        end
      end else begin
        cnt_d   = cnt_q + CW'(1);
        pload_o = (cnt_q + CW'(1) == per_q);
      end
    end else begin
      if (cnt_q <= CW'(1)) begin
        cnt_d   = '0;
        dir_d   = DIR_UP;
        vload_o = 1'b1;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
    per_d = vload_o ? period_i : per_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
      per_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
      per_q <= per_d;
    end
  end

  assign cnt_o = cnt_q;
  assign per_o = per_q;

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == '0) || (cnt_q == $past(cnt_q) + CW'(1)) || (cnt_q == $past(cnt_q) - CW'(1)));
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_q);
endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase #(
  parameter int CW  = 16,
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  cnt_i,
  input  logic [CW-1:0]  per_i,
  input  logic [CW-1:0]  duty_i,
  input  logic           wr_i,
  input  logic           vload_i,
  input  logic           pload_i,
  input  logic           dbl_i,
  input  logic [DTW-1:0] dt_i,
  output logic           hi_o,
  output logic           lo_o
);
  localparam int LW = CW + 2;

  logic [CW-1:0]        shd_q, shd_d, act_q, act_d;
  logic                 lvl_q, lvl_d;
  logic [DTW-1:0]       dtc_q, dtc_d;
  logic signed [LW-1:0] lim;
  logic                 full_on, full_off, ld_en;

  always_comb begin
    shd_d = wr_i ? duty_i : shd_q;
    ld_en = vload_i | (pload_i & dbl_i);
    act_d = ld_en ? shd_q : act_q;
    lim      = LW'({2'b00, per_i >> 1}) + LW'({{2{act_q[CW-1]}}, act_q});
    full_off = (lim <= 0);
    full_on  = (lim >= $signed(LW'({2'b00, per_i})));
    if (full_on)       lvl_d = 1'b1;
    else if (full_off) lvl_d = 1'b0;
    else               lvl_d = (cnt_i < lim[CW-1:0]);
    if (lvl_d != lvl_q)    dtc_d = '0;
    else if (dtc_q < dt_i) dtc_d = dtc_q + DTW'(1);
    else                   dtc_d = dtc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
      act_q <= '0;
      lvl_q <= 1'b0;
      dtc_q <= '0;
    end else begin
      shd_q <= shd_d;
      act_q <= act_d;
      lvl_q <= lvl_d;
      dtc_q <= dtc_d;
    end
  end

  assign hi_o = lvl_q  & (dtc_q >= dt_i);
  assign lo_o = ~lvl_q & (dtc_q >= dt_i);

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_o && lo_o));
  assert_guard_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl_q != $past(lvl_q)) && (dt_i != '0)) |-> (!hi_o && !lo_o));
endmodule

// File: rtl/pwm3_outstage.sv
module pwm3_outstage #(
  parameter int NPH = 3
) (
  input  logic [NPH-1:0]   hi_i,
  input  logic [NPH-1:0]   lo_i,
  input  logic [2*NPH-1:0] en_i,
  input  logic [NPH-1:0]   xov_i,
  input  logic             pol_i,
  input  logic             gate_i,
  output logic [2*NPH-1:0] pin_o
);
  for (genvar k = 0; k < NPH; k++) begin : g_pair
    logic a, b;
    always_comb begin
      a = xov_i[k] ? lo_i[k] : hi_i[k];
      b = xov_i[k] ? hi_i[k] : lo_i[k];
      pin_o[2*k]   = (a & en_i[2*k]   & ~gate_i) ^ ~pol_i;
      pin_o[2*k+1] = (b & en_i[2*k+1] & ~gate_i) ^ ~pol_i;
    end
  end
endmodule

// File: rtl/pwm3_center_top.sv
module pwm3_center_top #(
  parameter int CW  = 16,
  parameter int DTW = 8,
  parameter int NPH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    period_i,
  input  logic [NPH*CW-1:0] duty_i,
  input  logic             duty_wr_i,
  input  logic             dbl_i,
  input  logic [DTW-1:0]   dt_i,
  input  logic             sync_i,
  input  logic [2*NPH-1:0] en_i,
  input  logic [NPH-1:0]   xov_i,
  input  logic             pol_i,
  input  logic             shdn_i,
  input  logic             clr_i,
  output logic [2*NPH-1:0] pwm_o,
  output logic             trip_o
);
  logic [1:0]    rs_q;
  logic          rst_sn;
  logic [CW-1:0] cnt, per;
  logic          vload, pload;
  logic [NPH-1:0] hi, lo;
  logic          trip_q, trip_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  pwm3_timebase #(.CW(CW)) tb_i (
    .clk(clk), .rst_n(rst_sn), .period_i(period_i), .sync_i(sync_i),
    .cnt_o(cnt), .per_o(per), .vload_o(vload), .pload_o(pload)
  );

  for (genvar k = 0; k < NPH; k++) begin : g_ph
    pwm3_phase #(.CW(CW), .DTW(DTW)) ph_i (
      .clk(clk), .rst_n(rst_sn), .cnt_i(cnt), .per_i(per),
      .duty_i(duty_i[k*CW +: CW]), .wr_i(duty_wr_i),
      .vload_i(vload), .pload_i(pload), .dbl_i(dbl_i), .dt_i(dt_i),
      .hi_o(hi[k]), .lo_o(lo[k])
    );
  end

  always_comb trip_d = shdn_i | (trip_q & ~clr_i);

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) trip_q <= 1'b0;
    else         trip_q <= trip_d;
  end
  assign trip_o = trip_q;

  pwm3_outstage #(.NPH(NPH)) os_i (
    .hi_i(hi), .lo_i(lo), .en_i(en_i), .xov_i(xov_i), .pol_i(pol_i),
    .gate_i(shdn_i | trip_q), .pin_o(pwm_o)
  );

  assert_shdn_off_R12: assert property (@(posedge clk) disable iff (!rst_sn)
    shdn_i |-> (pwm_o == {2*NPH{~pol_i}}));
  assert_trip_off_R13: assert property (@(posedge clk) disable iff (!rst_sn)
    trip_o |-> (pwm_o == {2*NPH{~pol_i}}));
  assert_trip_set_R13: assert property (@(posedge clk) disable iff (!rst_sn)
    shdn_i |=> trip_o);
endmodule

// File: tb/pwm3_center_top_tb_top.sv
module pwm3_center_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] period_i;
  logic [47:0] duty_i;
  logic        duty_wr_i, dbl_i, sync_i, pol_i, shdn_i, clr_i;
  logic [7:0]  dt_i;
  logic [5:0]  en_i;
  logic [2:0]  xov_i;
  logic [5:0]  pwm_o;
  logic        trip_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  localparam int P = 20;

  int    q_start[$];
  int    q_len[$];
  string q_tag[$];
  int    q_exp[$];
  int    acc[6];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm3_center_top dut_i (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .duty_i(duty_i),
    .duty_wr_i(duty_wr_i), .dbl_i(dbl_i), .dt_i(dt_i), .sync_i(sync_i),
    .en_i(en_i), .xov_i(xov_i), .pol_i(pol_i), .shdn_i(shdn_i), .clr_i(clr_i),
    .pwm_o(pwm_o), .trip_o(trip_o)
  );

  // monitor: integrates per-pin on-counts over each queued window
  always @(negedge clk) begin
    if (q_start.size() > 0 && cyc >= q_start[0]) begin
      for (int i = 0; i < 6; i++) acc[i] += int'(pwm_o[i]);
      if (cyc == q_start[0] + q_len[0] - 1) begin
        for (int i = 0; i < 6; i++) begin
          total++;
          if (acc[i] != q_exp[i]) begin
            bad++;
            $display("FAIL %s pin%0d count: actual=%0d expected=%0d", q_tag[0], i, acc[i], q_exp[i]);
          end
          acc[i] = 0;
        end
        void'(q_start.pop_front());
        void'(q_len.pop_front());
        void'(q_tag.pop_front());
        for (int i = 0; i < 6; i++) void'(q_exp.pop_front());
      end
    end
  end

  task automatic push(input string tag, input int start, input int e0, input int e1,
                      input int e2, input int e3, input int e4, input int e5);
    q_start.push_back(start);
    q_len.push_back(2*P);
    q_tag.push_back(tag);
    q_exp.push_back(e0); q_exp.push_back(e1); q_exp.push_back(e2);
    q_exp.push_back(e3); q_exp.push_back(e4); q_exp.push_back(e5);
  endtask

  task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wr_duty(input logic signed [15:0] d0, input logic signed [15:0] d1,
                         input logic signed [15:0] d2);
    @(negedge clk);
    duty_i = {d2, d1, d0};
    duty_wr_i = 1'b1;
    @(negedge clk);
    duty_wr_i = 1'b0;
  endtask

  task automatic do_sync(output int c0);
    @(negedge clk);
    sync_i = 1'b1;
    @(negedge clk);
    sync_i = 1'b0;
    c0 = cyc;
  endtask

  task automatic drain();
    wait (q_start.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0;
    for (int i = 0; i < 6; i++) acc[i] = 0;
    rst_n = 1'b0; period_i = 16'(P); duty_i = '0; duty_wr_i = 1'b0; dbl_i = 1'b0;
    dt_i = 8'd0; sync_i = 1'b0; en_i = 6'h3f; xov_i = 3'b000; pol_i = 1'b1;
    shdn_i = 1'b0; clr_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset pins/trip", {trip_o, pwm_o}, 7'b0101010);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 R3 R6: base duties, window aligned to sync
    wr_duty(16'sd0, 16'sd4, -16'sd6);
    do_sync(c0);
    push("R2 R3 R6 base", c0 + 1, 19, 21, 27, 13, 7, 33);
    drain();

    // R4: clamped duties
    wr_duty(16'sd20, -16'sd32768, 16'sd10);
    do_sync(c0);
    push("R4 clamp", c0 + 1, 40, 0, 0, 40, 40, 0);
    drain();

    // R5: dead time 3, steady period after restart; phase 2 full on keeps no gap
    dt_i = 8'd3;
    wr_duty(16'sd0, 16'sd4, 16'sd15);
    do_sync(c0);
    push("R5 deadtime", c0 + 1 + 2*P, 16, 18, 24, 10, 40, 0);
    drain();
    dt_i = 8'd0;

    // R7: single update, write during up ramp
    wr_duty(16'sd0, 16'sd0, 16'sd0);
    do_sync(c0);
    push("R7 single old", c0 + 1, 19, 21, 19, 21, 19, 21);
    push("R7 single new", c0 + 1 + 2*P, 27, 13, 27, 13, 27, 13);
    repeat (3) @(negedge clk);
    wr_duty(16'sd4, 16'sd4, 16'sd4);
    drain();

    // R8: double update
    dbl_i = 1'b1;
    wr_duty(16'sd0, 16'sd0, 16'sd0);
    do_sync(c0);
    push("R8 double mixed", c0 + 1, 23, 17, 23, 17, 23, 17);
    push("R8 double new", c0 + 1 + 2*P, 27, 13, 27, 13, 27, 13);
    repeat (3) @(negedge clk);
    wr_duty(16'sd4, 16'sd4, 16'sd4);
    drain();
    dbl_i = 1'b0;

    // R9: per-pin enable
    wr_duty(16'sd0, 16'sd4, -16'sd6);
    en_i = 6'b110110;
    do_sync(c0);
    push("R9 enable", c0 + 1, 0, 21, 27, 0, 7, 33);
    drain();
    en_i = 6'h3f;

    // R10: crossover on phase 1
    xov_i = 3'b010;
    do_sync(c0);
    push("R10 crossover", c0 + 1, 19, 21, 13, 27, 7, 33);
    drain();
    xov_i = 3'b000;

    // R11: inverted polarity
    pol_i = 1'b0;
    do_sync(c0);
    push("R11 polarity", c0 + 1, 21, 19, 13, 27, 33, 7);
    drain();
    pol_i = 1'b1;

    // R12: shutdown without clock
    @(negedge clk);
    shdn_i = 1'b1;
    #1;
    chk("R12 shdn immediate", {trip_o, pwm_o}, 7'b0000000);
    pol_i = 1'b0;
    #1;
    chk("R12 shdn pol0", {1'b0, pwm_o}, 7'b0111111);
    pol_i = 1'b1;
    @(negedge clk);
    chk("R13 trip set", {trip_o, pwm_o}, 7'b1000000);
    clr_i = 1'b1;
    @(negedge clk);
    chk("R13 clr ignored under shdn", {trip_o, pwm_o}, 7'b1000000);
    clr_i = 1'b0;
    shdn_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R13 held after shdn low", {trip_o, pwm_o}, 7'b1000000);
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
    chk("R13 trip cleared", {trip_o, 6'b000000}, 7'b0000000);
    do_sync(c0);
    push("R13 resume", c0 + 1, 19, 21, 27, 13, 7, 33);
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule